// File: doc/BRIEF.md
# Two-Channel Low-Band Audio Conditioner

This block prepares a pair of 12-bit audio sample streams for low-frequency analysis. Each channel arrives as an unsigned code centred near mid-scale. The block first strips the standing offset with a leaky integrator. It then passes the result through a first-order low-pass filter whose corner comes from a 2-bit preset select. A fourth preset routes the offset-free sample around the filter without changing it. The two channels have their own integrator and filter registers and do not interact.

A sample pair is accepted on any clock where `in_valid` is high. The matching conditioned pair appears two clocks later together with `out_valid`. The preset is captured together with the sample it accompanies. Switching presets never clears the filter memory, so a return to a filtering preset continues from the state that was last held.

Control is a two-state path register. `PATH_LOWPASS` is entered on the transition "select filter" when a sample arrives with preset 0, 1 or 2. `PATH_THROUGH` is entered on the transition "select bypass" when a sample arrives with preset 3. The register holds its state while no sample arrives and resets to `PATH_LOWPASS`.

Top module: `lowband_conditioner`

## Requirements
- R1: For each accepted sample, let x = raw − 2048 and est = A >>> 10, where A is the signed 24-bit offset accumulator before the update. The offset-free sample is y = x − est, and the accumulator then becomes A + x − est.
- R2: Channel 0 and channel 1 each have their own accumulator and filter state. The output of one channel depends only on that channel's input history.
- R3: Preset codes 0, 1 and 2 select the Q15 coefficients 426, 679 and 1054. With state S held at 256× scale, the update is S ← S + ((alpha · ((y << 8) − S)) >>> 15), and the output is the new S >>> 8. Both shifts are arithmetic and round toward minus infinity.
- R4: Preset code 3 (bypass) outputs y unchanged.
- R5: A bypass sample leaves the filter state untouched. A change of preset takes effect with the sample it accompanies and never resets the filter state.
- R6: `out_valid` is high exactly two clocks after `in_valid` was high. The outputs of that cycle belong to that sample.
- R7: Reset clears both accumulators, both filter states, both outputs and `out_valid`.
- R8: While no sample is in flight, the outputs and the filter states keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample pair strobe |
| in_ch0 | input | 12 | Channel 0 raw unsigned sample |
| in_ch1 | input | 12 | Channel 1 raw unsigned sample |
| preset | input | 2 | 0 = 100 Hz, 1 = 160 Hz, 2 = 250 Hz, 3 = bypass |
| out_valid | output | 1 | Conditioned pair strobe |
| out_ch0 | output | 14 | Channel 0 conditioned sample, signed |
| out_ch1 | output | 14 | Channel 1 conditioned sample, signed |

## Verification
A corrupted offset accumulator shows up as a bias on the very next output. In bypass that bias is plain, and it persists for on the order of a thousand samples because the estimate decays only slowly. A wrong filter state or coefficient shows on the next filtering sample. After a bypass stretch, a filter state that was reset or disturbed shows on the first sample after the return to filtering. A sweep of every raw code under every preset, with interleaved idle cycles and preset hops, compares each output against exact integer arithmetic in the cycle the output is produced.

// File: rtl/lbc_pkg.sv
package lbc_pkg;

    typedef enum logic [1:0] {
        PRE_SUB  = 2'd0,
        PRE_LOW  = 2'd1,
        PRE_BASS = 2'd2,
        PRE_THRU = 2'd3
    } preset_e;

    typedef enum logic {
        PATH_LOWPASS = 1'b0,
        PATH_THROUGH = 1'b1
    } path_e;

    // Q15 smoothing coefficient per preset; bypass has no coefficient
    function automatic logic signed [15:0] coef_of(preset_e p);
        logic signed [15:0] c;
        unique case (p)
            PRE_SUB:  c = 16'sd426;
            PRE_LOW:  c = 16'sd679;
            PRE_BASS: c = 16'sd1054;
            PRE_THRU: c = 16'sd0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/lbc_dc_tracker.sv
module lbc_dc_tracker #(
    parameter int SAMPLE_W = 12,
    parameter int ACC_W    = 24,
    parameter int DC_SHIFT = 10,
    parameter int Y_W      = SAMPLE_W + 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       take,
    input  logic [SAMPLE_W-1:0]        raw,
    output logic signed [Y_W-1:0]      y_q
);
    localparam logic [SAMPLE_W:0] MID = (SAMPLE_W+1)'(1) << (SAMPLE_W - 1);

    logic signed [SAMPLE_W:0] x;
    logic signed [ACC_W-1:0]  acc_q;
    logic signed [ACC_W-1:0]  est;
    logic signed [ACC_W-1:0]  x_ext;
    logic signed [ACC_W-1:0]  y_wide;
    logic signed [ACC_W-1:0]  acc_n;

    always_comb begin
        x      = $signed({1'b0, raw}) - $signed(MID);
        x_ext  = ACC_W'(x);
        est    = acc_q >>> DC_SHIFT;
        y_wide = x_ext - est;
        acc_n  = acc_q + y_wide;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            y_q   <= '0;
        end else if (take) begin
            acc_q <= acc_n;
            y_q   <= Y_W'(y_wide);
        end
    end
endmodule

// File: rtl/lbc_onepole.sv
module lbc_onepole #(
    parameter int IN_W      = 14,
    parameter int FRAC      = 8,
    parameter int ST_W      = 24,
    parameter int COEF_W    = 16,
    parameter int COEF_FRAC = 15
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     take,
    input  logic signed [IN_W-1:0]   y,
    input  logic signed [COEF_W-1:0] coef,
    output logic signed [ST_W-1:0]   st_q,
    output logic signed [ST_W-1:0]   st_next
);
    localparam int PROD_W = ST_W + 1 + COEF_W;

    logic signed [ST_W:0]     target;
    logic signed [ST_W:0]     diff;
    logic signed [PROD_W-1:0] prod;

    always_comb begin
        target  = (ST_W+1)'(y) <<< FRAC;
        diff    = target - (ST_W+1)'(st_q);
        prod    = PROD_W'(diff) * PROD_W'(coef);
        st_next = st_q + ST_W'(prod >>> COEF_FRAC);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else if (take)
            st_q <= st_next;
    end
endmodule

// File: rtl/lbc_channel.sv
module lbc_channel
    import lbc_pkg::*;
#(
    parameter int SAMPLE_W  = 12,
    parameter int ACC_W     = 24,
    parameter int DC_SHIFT  = 10,
    parameter int FRAC      = 8,
    parameter int COEF_W    = 16,
    parameter int COEF_FRAC = 15,
    parameter int OUT_W     = SAMPLE_W + 2,
    parameter int ST_W      = OUT_W + FRAC + 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_take,
    input  logic [SAMPLE_W-1:0]      raw,
    input  logic                     s1_take,
    input  path_e                    path,
    input  logic signed [COEF_W-1:0] coef,
    output logic signed [OUT_W-1:0]  out_q,
    output logic signed [ST_W-1:0]   st_q
);
    logic signed [OUT_W-1:0] y_q;
    logic signed [ST_W-1:0]  st_next;
    logic                    filt_take;

    lbc_dc_tracker #(
        .SAMPLE_W (SAMPLE_W),
        .ACC_W    (ACC_W),
        .DC_SHIFT (DC_SHIFT),
        .Y_W      (OUT_W)
    ) u_dc (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (in_take),
        .raw   (raw),
        .y_q   (y_q)
    );

    assign filt_take = s1_take && (path == PATH_LOWPASS);

    lbc_onepole #(
        .IN_W      (OUT_W),
        .FRAC      (FRAC),
        .ST_W      (ST_W),
        .COEF_W    (COEF_W),
        .COEF_FRAC (COEF_FRAC)
    ) u_lp (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (filt_take),
        .y       (y_q),
        .coef    (coef),
        .st_q    (st_q),
        .st_next (st_next)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (s1_take) begin
            unique case (path)
                PATH_LOWPASS: out_q <= OUT_W'(st_next >>> FRAC);
                PATH_THROUGH: out_q <= y_q;
            endcase
        end
    end
endmodule

// File: rtl/lowband_conditioner.sv
module lowband_conditioner
    import lbc_pkg::*;
#(
    parameter int SAMPLE_W  = 12,
    parameter int ACC_W     = 24,
    parameter int DC_SHIFT  = 10,
    parameter int FRAC      = 8,
    parameter int COEF_W    = 16,
    parameter int COEF_FRAC = 15
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [SAMPLE_W-1:0]         in_ch0,
    input  logic [SAMPLE_W-1:0]         in_ch1,
    input  logic [1:0]                  preset,
    output logic                        out_valid,
    output logic signed [SAMPLE_W+1:0]  out_ch0,
    output logic signed [SAMPLE_W+1:0]  out_ch1
);
    localparam int N_CH  = 2;
    localparam int OUT_W = SAMPLE_W + 2;
    localparam int ST_W  = OUT_W + FRAC + 2;

    path_e                    path_q, path_n;
    logic signed [COEF_W-1:0] coef_q, coef_n;
    logic                     s1_valid_q;
    logic                     out_valid_q;

    logic [SAMPLE_W-1:0]      raw_arr   [N_CH];
    logic signed [OUT_W-1:0]  out_arr   [N_CH];
    logic signed [ST_W-1:0]   lp_state  [N_CH];

    // next path and coefficient from the preset arriving with the sample
    always_comb begin
        unique case (preset_e'(preset))
            PRE_THRU: path_n = PATH_THROUGH;
            PRE_SUB,
            PRE_LOW,
            PRE_BASS: path_n = PATH_LOWPASS;
        endcase
        coef_n = COEF_W'(coef_of(preset_e'(preset)));
    end

    // path state register: moves only when a sample is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            path_q <= PATH_LOWPASS;
            coef_q <= COEF_W'(coef_of(PRE_SUB));
        end else if (in_valid) begin
            path_q <= path_n;
            coef_q <= coef_n;
        end
    end

    // strobe pipeline
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid_q  <= 1'b0;
            out_valid_q <= 1'b0;
        end else begin
            s1_valid_q  <= in_valid;
            out_valid_q <= s1_valid_q;
        end
    end

    assign raw_arr[0] = in_ch0;
    assign raw_arr[1] = in_ch1;

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        lbc_channel #(
            .SAMPLE_W  (SAMPLE_W),
            .ACC_W     (ACC_W),
            .DC_SHIFT  (DC_SHIFT),
            .FRAC      (FRAC),
            .COEF_W    (COEF_W),
            .COEF_FRAC (COEF_FRAC),
            .OUT_W     (OUT_W),
            .ST_W      (ST_W)
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .in_take (in_valid),
            .raw     (raw_arr[g]),
            .s1_take (s1_valid_q),
            .path    (path_q),
            .coef    (coef_q),
            .out_q   (out_arr[g]),
            .st_q    (lp_state[g])
        );
    end

    assign out_valid = out_valid_q;
    assign out_ch0   = out_arr[0];
    assign out_ch1   = out_arr[1];
endmodule

// File: rtl/lowband_conditioner_chk.sv
module lowband_conditioner_chk
    import lbc_pkg::*;
#(
    parameter int OUT_W = 14,
    parameter int ST_W  = 24
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    out_valid,
    input logic signed [OUT_W-1:0] out_ch0,
    input logic signed [OUT_W-1:0] out_ch1,
    input logic                    s1_valid,
    input path_e                   path,
    input logic signed [ST_W-1:0]  st0,
    input logic signed [ST_W-1:0]  st1
);
    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (!rst_n)
            since_rst <= 2'd0;
        else if (since_rst != 2'd2)
            since_rst <= since_rst + 2'd1;
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd2) |-> (out_valid == $past(in_valid, 2))); // R6

    AST_RESET_CLEARS: assert property (@(posedge clk)
        $rose(rst_n) |-> (!out_valid && out_ch0 == '0 && out_ch1 == '0 && st0 == '0 && st1 == '0)); // R7

    AST_BYPASS_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && path == PATH_THROUGH) |=> ($stable(st0) && $stable(st1))); // R5

    AST_IDLE_HOLDS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_valid |=> ($stable(out_ch0) && $stable(out_ch1))); // R8

    AST_IDLE_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_valid |=> ($stable(st0) && $stable(st1))); // R8
endmodule

bind lowband_conditioner lowband_conditioner_chk #(
    .OUT_W (OUT_W),
    .ST_W  (ST_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_ch0   (out_ch0),
    .out_ch1   (out_ch1),
    .s1_valid  (s1_valid_q),
    .path      (path_q),
    .st0       (lp_state[0]),
    .st1       (lp_state[1])
);

// File: tb/lowband_conditioner_bench.sv
module lowband_conditioner_bench;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic [11:0]        in_ch0 = '0;
    logic [11:0]        in_ch1 = '0;
    logic [1:0]         preset = '0;
    logic               out_valid;
    logic signed [13:0] out_ch0;
    logic signed [13:0] out_ch1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    int acc [2];
    int st  [2];
    int exp_out [2];
    int pend_out [2];
    bit pend_v = 1'b0;
    string pend_tag = "R6";

    always #10 clk = ~clk;

    lowband_conditioner u_lowband_conditioner (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ch0    (in_ch0),
        .in_ch1    (in_ch1),
        .preset    (preset),
        .out_valid (out_valid),
        .out_ch0   (out_ch0),
        .out_ch1   (out_ch1)
    );

    task automatic check_eq(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic longint alpha_of(int p);
        case (p)
            0: return 426;
            1: return 679;
            2: return 1054;
            default: return 0;
        endcase
    endfunction

    function automatic int model(int ch, int raw, int p);
        int x;
        int est;
        int y;
        longint d;
        x = raw - 2048;
        est = acc[ch] >>> 10;
        y = x - est;
        acc[ch] = acc[ch] + x - est;
        if (p == 3) return y;
        d = (longint'(y) <<< 8) - longint'(st[ch]);
        st[ch] = st[ch] + int'((alpha_of(p) * d) >>> 15);
        return st[ch] >>> 8;
    endfunction

    function automatic void model_reset();
        for (int c = 0; c < 2; c++) begin
            acc[c] = 0; st[c] = 0; exp_out[c] = 0; pend_out[c] = 0;
        end
        pend_v = 1'b0;
    endfunction

    // one clock: drive at negedge, check outputs of the previous step at next negedge
    task automatic step(bit v, int a, int b, int p, string tag);
        int n0;
        int n1;
        n0 = 0; n1 = 0;
        in_valid = v; in_ch0 = 12'(a); in_ch1 = 12'(b); preset = 2'(p);
        if (v) begin
            n0 = model(0, a, p);
            n1 = model(1, b, p);
        end
        @(posedge clk);
        @(negedge clk);
        if (pend_v) begin
            exp_out[0] = pend_out[0];
            exp_out[1] = pend_out[1];
        end
        check_eq("R6", "out_valid", int'(out_valid), int'(pend_v));
        check_eq(pend_v ? pend_tag : "R8", "out_ch0", int'(out_ch0), exp_out[0]);
        check_eq(pend_v ? pend_tag : "R8", "out_ch1", int'(out_ch1), exp_out[1]);
        pend_v = v;
        pend_out[0] = n0;
        pend_out[1] = n1;
        pend_tag = tag;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        in_valid = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check_eq("R7", "out_valid in reset", int'(out_valid), 0);
        check_eq("R7", "out_ch0 in reset", int'(out_ch0), 0);
        check_eq("R7", "out_ch1 in reset", int'(out_ch1), 0);
        model_reset();
        rst_n = 1'b1;
    endtask

    initial begin
        int mag;
        model_reset();
        @(negedge clk);
        do_reset();

        // R1: constant offsets in bypass; offset must decay
        for (int i = 0; i < 3000; i++) step(1'b1, 2148, 1948, 3, "R1");
        step(1'b0, 0, 0, 3, "R8");
        step(1'b0, 0, 0, 3, "R8");
        mag = int'(out_ch0) < 0 ? -int'(out_ch0) : int'(out_ch0);
        check_eq("R1", "residual offset below 20", int'(mag < 20), 1);

        // R3 / R4: every raw code under every preset, with idle gaps (R8)
        for (int p = 0; p < 4; p++) begin
            for (int i = 0; i < 4096; i++) begin
                if (i % 97 == 0) step(1'b0, 0, 0, p, "R8");
                step(1'b1, i, (i * 37 + 11) % 4096, p, p == 3 ? "R4" : "R3");
            end
        end

        // R5: preset hops on a square wave, state carried across bypass
        for (int i = 0; i < 400; i++) begin
            int seq [5] = '{0, 3, 1, 3, 2};
            step(1'b1, ((i / 16) % 2) ? 2300 : 1800, ((i / 8) % 2) ? 1700 : 2400,
                 seq[(i / 10) % 5], "R5");
        end

        // R2: channel 1 quiet while channel 0 swings hard
        for (int i = 0; i < 300; i++)
            step(1'b1, ((i / 5) % 2) ? 4095 : 0, 2048, 1, "R2");
        step(1'b0, 0, 0, 1, "R8");
        step(1'b0, 0, 0, 1, "R8");

        // R7: reset in mid-stream, then resume
        step(1'b1, 3000, 1000, 0, "R3");
        do_reset();
        for (int i = 0; i < 50; i++) step(1'b1, 2500 - i * 7, 1600 + i * 9, 2, "R7");
        step(1'b0, 0, 0, 2, "R8");
        step(1'b0, 0, 0, 2, "R8");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R6 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule